// File: doc/BRIEF.md
# Banked Byte Register Space

This block maps every register operand of a small 8-bit core onto a 144-byte physical store. An instruction names a register with only five address bits, so it sees a 32-byte window. The lower half of that window never moves. It holds eight special-function slots and eight general-purpose bytes that every bank shares. The upper half is one of eight 16-byte banks, and the bank is chosen by the top three bits of a file select register (FSR) that lives inside the block. Across all banks this gives 136 general-purpose bytes next to the eight special-function slots.

Indirect access takes the whole 8-bit FSR as the effective address and applies the same split between fixed and banked addresses. It is requested with a flag, or by naming direct address 0x00. The block has one combinational read port and one clocked write port. It holds the FSR itself and exposes its value. Accesses to the other special-function slots are passed to the surrounding logic through simple hook signals.

Top module: `banked_regfile`

## Requirements
- R1: A direct access (indirect flag low, address not 0x00) uses the effective address {FSR[7:5], addr[4:0]}.
- R2: Effective addresses whose bit 4 is 0 and whose low nibble is 0x8 to 0xF reach eight general-purpose bytes that are the same for every value of FSR[7:5].
- R3: Effective addresses whose bit 4 is 1 reach byte addr[3:0] of bank FSR[7:5]. The eight banks are independent. Writing 0x90 to the FSR and then writing direct address 0x10 stores into bank 4.
- R4: Slot 0x04 of the fixed half is the FSR. It can be read and written like any register, and its current value is always driven on `fsr_o`.
- R5: When the indirect flag is set, or the direct address is 0x00, the effective address is the full FSR value, and it is mapped by the rules of R2, R3, R4 and R7.
- R6: An effective address whose low five bits are 0 reads as 0x00. A write to it changes no byte, leaves the FSR unchanged and raises no hook strobe.
- R7: Fixed-half slots 0x01, 0x02, 0x03, 0x05, 0x06 and 0x07 are external. A read raises `sfr_rd_hit` with the slot number on `sfr_rd_slot` and returns `sfr_rd_data`. A write raises `sfr_wr_en` with the slot number and data in the same cycle. Slot 0x04 raises neither hook.
- R8: Reads follow the current address and FSR with no clock delay. Writes take effect at the next rising edge. A read in the write's cycle sees the old value, and an FSR write changes the bank from the following cycle onward.
- R9: Reset, active low, clears all 136 general-purpose bytes and the FSR to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | 5 | Direct read operand address |
| rd_ind | input | 1 | Read uses the FSR as address |
| rd_data | output | 8 | Read result, combinational |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Direct write operand address |
| wr_ind | input | 1 | Write uses the FSR as address |
| wr_data | input | 8 | Write value |
| fsr_o | output | 8 | Current file select register |
| sfr_rd_hit | output | 1 | Read targets an external slot |
| sfr_rd_slot | output | 3 | Slot number of that read |
| sfr_rd_data | input | 8 | Value returned by the external slot |
| sfr_wr_en | output | 1 | Write targets an external slot |
| sfr_wr_slot | output | 3 | Slot number of that write |
| sfr_wr_data | output | 8 | Value for the external slot |

## Verification
The bench builds the block with its default BANK_W of 3, so all eight banks are present. It writes a distinct byte into the top location of every bank, from bank 0 to bank 7, and reads each one back, so aliasing between banks or an error in the high bank bits becomes visible. With the full 8-bit FSR reachable, indirect pointers can land in the fixed half and on the FSR itself from a non-zero bank. They can also land on the zero-offset addresses of several banks.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int DW       = 8;
  localparam int DIR_W    = 5;
  localparam int WIN      = 16;
  localparam int SFR_N    = 8;
  localparam int GLB_GP   = WIN - SFR_N;
  localparam int FSR_SLOT = 4;

  typedef enum logic [1:0] {K_NULL, K_FSR, K_SFR, K_GP} kind_t;

  typedef struct packed {
    kind_t      kind;
    logic [2:0] slot;
    logic [7:0] idx;
  } acc_t;

  // Effective address: full FSR when indirect, else bank bits over operand.
  function automatic logic [7:0] eff_addr(logic [4:0] a, logic ind, logic [7:0] fsr);
    if (ind || a == 5'd0) return fsr;
    return {fsr[7:5], a};
  endfunction

  // Physical general-purpose index: fixed bytes first, then banks of WIN.
  function automatic logic [7:0] gp_index(logic [2:0] bank, logic [4:0] low);
    if (!low[4]) return {4'd0, low[3:0]} - 8'(SFR_N);
    return 8'(GLB_GP) + {1'b0, bank, 4'b0000} + {4'd0, low[3:0]};
  endfunction
endpackage

// File: rtl/brf_decode.sv
module brf_decode
  import brf_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic [4:0] addr,
  input  logic       ind,
  input  logic [7:0] fsr,
  output logic [7:0] ea,
  output acc_t       acc
);
  localparam logic [2:0] BANK_MASK = 3'((1 << BANK_W) - 1);

  logic [2:0] bank_m;

  assign ea     = eff_addr(addr, ind, fsr);
  assign bank_m = ea[7:5] & BANK_MASK;

  always_comb begin
    acc = '0;
    if (ea[4:0] == 5'd0) begin
      acc.kind = K_NULL;
    end else if (!ea[4] && int'(ea[3:0]) < SFR_N) begin
      acc.slot = ea[2:0];
      acc.kind = (int'(ea[2:0]) == FSR_SLOT) ? K_FSR : K_SFR;
    end else begin
      acc.kind = K_GP;
      acc.idx  = gp_index(bank_m, ea[4:0]);
    end
  end

  // R2: a fixed-half address never lands in a bank region
  always_comb begin
    if (acc.kind == K_GP && !ea[4])
      a_r2_fixed_unbanked: assert (int'(acc.idx) < GLB_GP);
  end
endmodule

// File: rtl/brf_store.sv
module brf_store
  import brf_pkg::*;
#(
  parameter int DEPTH = 136
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [7:0]    widx,
  input  logic [DW-1:0] wdata,
  input  logic [7:0]    ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = (int'(ridx) < DEPTH) ? mem[ridx] : '0;

  a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> int'(widx) < DEPTH);

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(widx)] == $past(wdata));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] rd_addr,
  input  logic       rd_ind,
  output logic [7:0] rd_data,
  input  logic       wr_en,
  input  logic [4:0] wr_addr,
  input  logic       wr_ind,
  input  logic [7:0] wr_data,
  output logic [7:0] fsr_o,
  output logic       sfr_rd_hit,
  output logic [2:0] sfr_rd_slot,
  input  logic [7:0] sfr_rd_data,
  output logic       sfr_wr_en,
  output logic [2:0] sfr_wr_slot,
  output logic [7:0] sfr_wr_data
);
  localparam int NBANK    = 1 << BANK_W;
  localparam int GP_DEPTH = GLB_GP + NBANK * WIN;

  logic [7:0] fsr_q, rd_ea, wr_ea, gp_rdata;
  acc_t       rd_acc, wr_acc;
  logic       gp_we, fsr_we, null_wr_drop;

  brf_decode #(.BANK_W(BANK_W)) u_dec_rd (
    .addr(rd_addr), .ind(rd_ind), .fsr(fsr_q), .ea(rd_ea), .acc(rd_acc));

  brf_decode #(.BANK_W(BANK_W)) u_dec_wr (
    .addr(wr_addr), .ind(wr_ind), .fsr(fsr_q), .ea(wr_ea), .acc(wr_acc));

  assign gp_we        = wr_en && wr_acc.kind == K_GP;
  assign fsr_we       = wr_en && wr_acc.kind == K_FSR;
  assign null_wr_drop = wr_en && wr_acc.kind == K_NULL;

  brf_store #(.DEPTH(GP_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(gp_we), .widx(wr_acc.idx), .wdata(wr_data),
    .ridx(rd_acc.idx), .rdata(gp_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fsr_q <= '0;
    else if (fsr_we) fsr_q <= wr_data;
  end

  assign fsr_o       = fsr_q;
  assign sfr_rd_hit  = rd_acc.kind == K_SFR;
  assign sfr_rd_slot = rd_acc.slot;
  assign sfr_wr_en   = wr_en && wr_acc.kind == K_SFR;
  assign sfr_wr_slot = wr_acc.slot;
  assign sfr_wr_data = wr_data;

  always_comb begin
    unique case (rd_acc.kind)
      K_NULL:  rd_data = '0;
      K_FSR:   rd_data = fsr_q;
      K_SFR:   rd_data = sfr_rd_data;
      default: rd_data = gp_rdata;
    endcase
  end

  a_r4_fsr_load: assert property (@(posedge clk) disable iff (!rst_n)
    fsr_we |=> fsr_o == $past(wr_data));

  a_r8_fsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fsr_we |=> $stable(fsr_o));

  a_r6_null_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    null_wr_drop |-> !gp_we && !fsr_we && !sfr_wr_en);

  a_r7_hook_slot: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rd_hit |-> sfr_rd_slot != 3'(FSR_SLOT) && sfr_rd_slot != 3'd0);
endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] rd_addr = '0, wr_addr = '0;
  logic       rd_ind = 1'b0, wr_ind = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0, rd_data, fsr_o, sfr_rd_data, sfr_wr_data;
  logic       sfr_rd_hit, sfr_wr_en;
  logic [2:0] sfr_rd_slot, sfr_wr_slot;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sfr_rd_data = 8'hA0 | {5'd0, sfr_rd_slot};

  banked_regfile i_banked_regfile (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_ind(rd_ind), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_ind(wr_ind), .wr_data(wr_data),
    .fsr_o(fsr_o), .sfr_rd_hit(sfr_rd_hit), .sfr_rd_slot(sfr_rd_slot),
    .sfr_rd_data(sfr_rd_data), .sfr_wr_en(sfr_wr_en), .sfr_wr_slot(sfr_wr_slot),
    .sfr_wr_data(sfr_wr_data));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic ind, logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_ind = ind; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic ind, logic [7:0] exp);
    @(negedge clk);
    rd_addr = a; rd_ind = ind;
    #2;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R9 fsr", fsr_o, 8'h00);
    rd_chk("R9 fixed 08", 5'h08, 1'b0, 8'h00);
    rd_chk("R9 bank0 10", 5'h10, 1'b0, 8'h00);
    rd_chk("R9 bank0 1F", 5'h1F, 1'b0, 8'h00);
  endtask

  task automatic t_bank_example;
    wr(5'h04, 1'b0, 8'h90);
    chk("R4 fsr_o", fsr_o, 8'h90);
    rd_chk("R4 read 04", 5'h04, 1'b0, 8'h90);
    wr(5'h10, 1'b0, 8'h64);
    rd_chk("R3 bank4 10", 5'h10, 1'b0, 8'h64);
    wr(5'h04, 1'b0, 8'h00);
    rd_chk("R3 bank0 10 untouched", 5'h10, 1'b0, 8'h00);
    wr(5'h10, 1'b0, 8'h11);
    rd_chk("R1 bank0 10", 5'h10, 1'b0, 8'h11);
  endtask

  task automatic t_all_banks;
    for (int b = 0; b < 8; b++) begin
      wr(5'h04, 1'b0, 8'(b << 5));
      wr(5'h1F, 1'b0, 8'(8'h30 + b));
    end
    for (int b = 0; b < 8; b++) begin
      wr(5'h04, 1'b0, 8'(b << 5));
      rd_chk($sformatf("R3 bank%0d 1F", b), 5'h1F, 1'b0, 8'(8'h30 + b));
    end
  endtask

  task automatic t_fixed;
    wr(5'h04, 1'b0, 8'h00);
    wr(5'h08, 1'b0, 8'h5A);
    wr(5'h0F, 1'b0, 8'hA5);
    wr(5'h04, 1'b0, 8'hE0);
    rd_chk("R2 08 from bank7", 5'h08, 1'b0, 8'h5A);
    rd_chk("R2 0F from bank7", 5'h0F, 1'b0, 8'hA5);
    wr(5'h04, 1'b0, 8'h60);
    rd_chk("R2 0F from bank3", 5'h0F, 1'b0, 8'hA5);
  endtask

  task automatic t_indirect;
    wr(5'h04, 1'b0, 8'h90);
    rd_chk("R5 flag read bank4 10", 5'h1B, 1'b1, 8'h64);
    rd_chk("R5 addr00 read", 5'h00, 1'b0, 8'h64);
    wr(5'h03, 1'b1, 8'h77);
    rd_chk("R5 indirect write landed", 5'h10, 1'b0, 8'h77);
    wr(5'h04, 1'b0, 8'h08);
    rd_chk("R5 indirect to fixed 08", 5'h00, 1'b0, 8'h5A);
    wr(5'h04, 1'b0, 8'hA4);
    rd_chk("R5 indirect to fsr", 5'h05, 1'b1, 8'hA4);
  endtask

  task automatic t_null;
    wr(5'h04, 1'b0, 8'h80);
    rd_chk("R6 null read", 5'h00, 1'b0, 8'h00);
    rd_chk("R6 null read flag", 5'h12, 1'b1, 8'h00);
    @(negedge clk);
    wr_addr = 5'h00; wr_ind = 1'b0; wr_data = 8'hFF; wr_en = 1'b1;
    #2;
    chk("R6 no hook strobe", {7'd0, sfr_wr_en}, 8'h00);
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R6 fsr kept", fsr_o, 8'h80);
    rd_chk("R6 bank4 10 kept", 5'h10, 1'b0, 8'h77);
    rd_chk("R6 fixed 08 kept", 5'h08, 1'b0, 8'h5A);
  endtask

  task automatic t_hooks;
    rd_chk("R7 slot2 data", 5'h02, 1'b0, 8'hA2);
    chk("R7 rd hit", {7'd0, sfr_rd_hit}, 8'h01);
    chk("R7 rd slot", {5'd0, sfr_rd_slot}, 8'h02);
    rd_chk("R7 slot4 internal", 5'h04, 1'b0, 8'h80);
    chk("R7 no hit on fsr", {7'd0, sfr_rd_hit}, 8'h00);
    @(negedge clk);
    wr_addr = 5'h07; wr_ind = 1'b0; wr_data = 8'h3C; wr_en = 1'b1;
    #2;
    chk("R7 wr strobe", {7'd0, sfr_wr_en}, 8'h01);
    chk("R7 wr slot", {5'd0, sfr_wr_slot}, 8'h07);
    chk("R7 wr data", sfr_wr_data, 8'h3C);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic t_timing;
    wr(5'h04, 1'b0, 8'h00);
    @(negedge clk);
    wr_addr = 5'h09; wr_ind = 1'b0; wr_data = 8'h12; wr_en = 1'b1;
    rd_addr = 5'h09; rd_ind = 1'b0;
    #2;
    chk("R8 old value same cycle", rd_data, 8'h00);
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R8 new value after edge", rd_data, 8'h12);
    @(negedge clk);
    wr_addr = 5'h04; wr_data = 8'h20; wr_en = 1'b1;
    rd_addr = 5'h1F;
    #2;
    chk("R8 bank unchanged in write cycle", rd_data, 8'h30);
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R8 bank1 after edge", rd_data, 8'h31);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_bank_example();
    t_all_banks();
    t_fixed();
    t_indirect();
    t_null();
    t_hooks();
    t_timing();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule